// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked system to an external asynchronous static RAM of 256K bytes. The memory is selected by two chip-enable pins of opposite polarity. It also has an active-low write strobe, an active-low read (output) enable and a shared 8-bit data bus. Here that bus is split into an output value, an output enable and an input value, and the pad ring joins them into the bidirectional pins.

The user side offers one request at a time: an address, a write flag and write data. The controller accepts the request only while `req_ready` is high. It returns a one-cycle `rsp_done` pulse when the memory cycle ends, and for reads `rsp_rdata` holds the captured byte.

Every memory phase lasts a fixed number of clock cycles. These counts are derived at elaboration from the clock period and from the memory's nanosecond limits:
- read access time;
- write pulse width;
- address-to-write-end time;
- data setup;
- write cycle time;
- bus release time.

With the default 8 ns clock, a read holds the pins for 9 cycles, a write holds the strobe low for 8 cycles, and a read is followed by 4 deselected cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and right after reset the memory is deselected (`mem_sel_n`=1, `mem_sel`=0), `mem_wr_n`=1, `mem_rd_n`=1, `mem_dq_oe`=0, `rsp_done`=0 and `req_ready`=1. A reset in the middle of a transaction returns the pins to this state at the next clock edge.
- R2: `req_ready` is high only while the controller is idle. A request presented while `req_ready` is low is ignored: it produces no memory cycle, no write and no done pulse.
- R3: A read drives `mem_sel_n`=0, `mem_sel`=1, `mem_rd_n`=0 and `mem_wr_n`=1 for exactly RD_CYC cycles (9 by default, ceil(70/8)). The bus is sampled on the edge that ends this window. `rsp_done` goes high on the (RD_CYC+1)-th edge after the accepting edge, with the byte on `rsp_rdata`.
- R4: A write holds `mem_wr_n` low for exactly WE_CYC cycles, with the data driven and `mem_rd_n` high throughout. WE_CYC is 8 by default: the largest of ceil(50/8), ceil(60/8), ceil(30/8) and ceil(70/8)-1. One further selected cycle follows with `mem_wr_n` high and the data still driven. `rsp_done` and `req_ready` then rise together on the (WE_CYC+2)-th edge after the accepting edge.
- R5: `mem_addr` equals the accepted address for every cycle in which the memory is selected.
- R6: `mem_dq_oe` is high only during write phases, never while `mem_rd_n` is low and never while the memory is deselected. The memory and the controller never drive the bus at the same time.
- R7: After the read done pulse, `req_ready` stays low and the memory stays deselected for TURN_CYC cycles (4 by default, ceil(25/8)). Only then can a write drive the bus.
- R8: Each accepted transaction that runs to completion gives exactly one `rsp_done` pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 18 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable of the memory |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_i | input | 8 | Data bus as seen from the pins |

## Verification
A phase counter that ends early shows up in one of two ways. On a read, the byte is sampled while the memory model still returns a corrupted value, so `rsp_rdata` is wrong at the very done pulse. On a write, the strobe is too short for the model's setup check, and the damage appears at the next read of that address. A state that keeps the data driver on into a read or a turnaround gives bus contention within the same cycle. A stuck state never returns `req_ready`, and a lost done pulse or a request taken while busy changes the done count and the stored bytes. Pin levels and strobe widths are also counted cycle by cycle for each transaction, so an off-by-one in any count appears within one transaction.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_TURN  = 3'd2,
        ST_WRITE = 3'd3,
        ST_WEND  = 3'd4
    } ctrl_state_e;

    // Whole clock cycles needed to cover a time in ns (rounded up)
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned per_ns);
        return (t_ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Down-counter pacing each memory phase; expired when it reaches zero.
module sram_ctrl_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_pins.sv
// Maps registered phase flags onto memory pin polarities.
module sram_ctrl_pins #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic              drv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdat,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);
    assign mem_addr  = addr;
    assign mem_sel_n = ~sel;
    assign mem_sel   = sel;
    assign mem_wr_n  = ~(wr & sel);
    assign mem_rd_n  = ~(rd & sel);
    assign mem_dq_o  = wdat;
    assign mem_dq_oe = drv & sel;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_ACC_NS  = 70,
    parameter int unsigned T_WPW_NS  = 50,
    parameter int unsigned T_AW_NS   = 60,
    parameter int unsigned T_DS_NS   = 30,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_REL_NS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned RD_CYC   = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned WC_LOW   = (ns_to_cyc(T_WC_NS, CLK_NS) > 1) ? ns_to_cyc(T_WC_NS, CLK_NS) - 1 : 1;
    localparam int unsigned WE_CYC   = max_u(max_u(ns_to_cyc(T_WPW_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                             max_u(ns_to_cyc(T_DS_NS, CLK_NS), WC_LOW));
    localparam int unsigned TURN_CYC = max_u(ns_to_cyc(T_REL_NS, CLK_NS), 1);
    localparam int unsigned MAX_CYC  = max_u(max_u(RD_CYC, WE_CYC), TURN_CYC);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic              sel;
        logic              wr;
        logic              rd;
        logic              drv;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
    } ctrl_regs_t;

    ctrl_regs_t       d, q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr   = req_addr;
                    d.wdat   = req_wdata;
                    d.sel    = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        d.st    = ST_WRITE;
                        d.wr    = 1'b1;
                        d.drv   = 1'b1;
                        tmr_val = CNT_W'(WE_CYC - 1);
                    end else begin
                        d.st    = ST_READ;
                        d.rd    = 1'b1;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    d.rdat   = mem_dq_i;
                    d.sel    = 1'b0;
                    d.rd     = 1'b0;
                    d.done   = 1'b1;
                    d.st     = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_TURN: begin
                if (tmr_zero) d.st = ST_IDLE;
            end
            ST_WRITE: begin
                if (tmr_zero) begin
                    d.wr = 1'b0;
                    d.st = ST_WEND;
                end
            end
            ST_WEND: begin
                d.sel  = 1'b0;
                d.drv  = 1'b0;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    sram_ctrl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .sel       (q.sel),
        .wr        (q.wr),
        .rd        (q.rd),
        .drv       (q.drv),
        .addr      (q.addr),
        .wdat      (q.wdat),
        .mem_addr  (mem_addr),
        .mem_sel_n (mem_sel_n),
        .mem_sel   (mem_sel),
        .mem_wr_n  (mem_wr_n),
        .mem_rd_n  (mem_rd_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe)
    );

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_done  = q.done;
    assign rsp_rdata = q.rdat;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned WE_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic              mem_dq_oe
);
    localparam int unsigned LW = $clog2(WE_CYC + 2);

    logic [LW-1:0] wr_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)         wr_low_cnt <= '0;
        else if (!mem_wr_n) wr_low_cnt <= wr_low_cnt + 1'b1;
        else                wr_low_cnt <= '0;
    end

    // R1 / R2: idle means deselected
    a_r2_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel));

    // R3: read enable never overlaps the write strobe
    a_r3_read_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> mem_wr_n);

    // R4: write strobe only while selected
    a_r4_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_sel_n && mem_sel));

    // R4: strobe low for exactly WE_CYC cycles
    a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (wr_low_cnt == LW'(WE_CYC)));

    // R5: address held while selected
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

    // R6: controller drives only with memory outputs off and memory selected
    a_r6_drive_rd_off: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_rd_n);

    a_r6_drive_selected: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_sel_n);

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind sram_async_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .WE_CYC(WE_CYC)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_wr_n  (mem_wr_n),
    .mem_rd_n  (mem_rd_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_behav_model.sv
// Behavioural asynchronous SRAM. One time unit stands for 1 ns.
// Before the access time has elapsed it returns the inverted byte.
// It counts setup violations and bus contention in viol.
module sram_behav_model #(
    parameter int T_ACC = 70,
    parameter int T_OE  = 35,
    parameter int T_REL = 25,
    parameter int T_WP  = 50,
    parameter int T_AW  = 60,
    parameter int T_DS  = 30
) (
    input  logic [17:0] addr,
    input  logic        sel_n,
    input  logic        sel,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic [7:0]  din,
    input  logic        din_en,
    output logic [7:0]  dout,
    output logic        dout_en,
    output int          viol
);
    logic [7:0] mem [int];
    longint t_addr = 0, t_sel = 0, t_rd = 0, t_wr = 0, t_din = 0, t_off = -1000;
    logic [17:0] p_addr = '0;
    logic        p_sel = 1'b0, p_rd = 1'b0, p_wr = 1'b0, p_den = 1'b0;
    logic [7:0]  p_din = '0;

    initial begin
        viol    = 0;
        dout    = '0;
        dout_en = 1'b0;
    end

    function automatic logic [7:0] peek(input logic [17:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'h00;
    endfunction

    always begin
        #1;
        begin
            longint now;
            logic   s, r, w;
            now = longint'($time);
            s   = !sel_n && sel;
            r   = s && !rd_n && wr_n;
            w   = s && !wr_n;
            // write ends on the first step the overlap is gone
            if (p_wr && !w) begin
                if (!p_den || (now - t_din) < T_DS || (now - t_wr) < T_WP || (now - t_addr) < T_AW) begin
                    viol = viol + 1;
                    $display("model: write setup violation at %0t addr %05h", $time, p_addr);
                end else begin
                    mem[int'(p_addr)] = p_din;
                end
            end
            if (addr != p_addr)                    t_addr = now;
            if (s != p_sel)                        t_sel  = now;
            if (r != p_rd)                         t_rd   = now;
            if (w && !p_wr)                        t_wr   = now;
            if (din != p_din || din_en != p_den)   t_din  = now;
            if (r) begin
                t_off   = now;
                dout_en = 1'b1;
                if ((now - t_addr) >= T_ACC && (now - t_sel) >= T_ACC && (now - t_rd) >= T_OE)
                    dout = peek(addr);
                else
                    dout = ~peek(addr);
            end else begin
                dout_en = (now - t_off) < T_REL;
            end
            if (dout_en && din_en) begin
                viol = viol + 1;
                $display("model: bus contention at %0t", $time);
            end
            p_addr = addr;
            p_sel  = s;
            p_rd   = r;
            p_wr   = w;
            p_din  = din;
            p_den  = din_en;
        end
    end
endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
    localparam int EXP_RD   = 9;   // R3: ceil(70/8)
    localparam int EXP_WE   = 8;   // R4
    localparam int EXP_TURN = 4;   // R7: ceil(25/8)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
    logic [7:0]  mem_dq_o, mem_dq_i, m_dq;
    logic        m_oe;
    int          m_viol;

    int checks = 0, fails = 0, done_seen = 0, done_exp = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign mem_dq_i = mem_dq_oe ? mem_dq_o : (m_oe ? m_dq : 8'h00);

    sram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n),
        .mem_rd_n(mem_rd_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    sram_behav_model u_mem (
        .addr(mem_addr), .sel_n(mem_sel_n), .sel(mem_sel), .wr_n(mem_wr_n),
        .rd_n(mem_rd_n), .din(mem_dq_o), .din_en(mem_dq_oe),
        .dout(m_dq), .dout_en(m_oe), .viol(m_viol)
    );

    always @(negedge clk) if (rst_n && rsp_done) done_seen++;

    typedef struct packed {
        logic        wr;
        logic [17:0] a;
        logic [7:0]  d;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 18'h00000, 8'h3C},
        '{1'b1, 18'h3FFFF, 8'hC3},
        '{1'b1, 18'h15555, 8'h5A},
        '{1'b1, 18'h2AAAA, 8'hA5},
        '{1'b0, 18'h00000, 8'h3C},
        '{1'b0, 18'h3FFFF, 8'hC3},
        '{1'b0, 18'h15555, 8'h5A},
        '{1'b0, 18'h2AAAA, 8'hA5},
        '{1'b1, 18'h15555, 8'h0F},
        '{1'b0, 18'h15555, 8'h0F},
        '{1'b0, 18'h3FFFF, 8'hC3},
        '{1'b1, 18'h00001, 8'hFF},
        '{1'b0, 18'h00001, 8'hFF}
    };

    task automatic check_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Runs one transaction and measures it at the pins
    task automatic run_txn(input logic wr, input logic [17:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output int lat, output int wr_lo,
                           output int rd_lo, output int turn, output int bad);
        int guard;
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; wr_lo = 0; rd_lo = 0; bad = 0;
        forever begin
            if (!mem_wr_n) wr_lo++;
            if (!mem_rd_n) rd_lo++;
            if (!mem_sel_n && mem_addr != a) bad++;
            if (wr && !mem_rd_n) bad++;
            if (!wr && mem_dq_oe) bad++;
            if (rsp_done || lat > 60) break;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        turn = 0;
        while (!req_ready && turn < 50) begin
            if (mem_dq_oe || !mem_sel_n) bad++;
            @(negedge clk);
            turn++;
        end
        done_exp++;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int lat, wr_lo, rd_lo, turn, bad;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1 sel_n in reset", mem_sel_n, 1);
        check_eq("R1 sel in reset", mem_sel, 0);
        check_eq("R1 wr_n/rd_n in reset", {mem_wr_n, mem_rd_n}, 2'b11);
        check_eq("R1 drive/done in reset", {mem_dq_oe, rsp_done}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 ready after reset", req_ready, 1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_txn(VECS[i].wr, VECS[i].a, VECS[i].d, rd, lat, wr_lo, rd_lo, turn, bad);
            check_eq($sformatf("R5 R6 pin misuse vec %0d", i), bad, 0);
            if (VECS[i].wr) begin
                check_eq($sformatf("R4 strobe width vec %0d", i), wr_lo, EXP_WE);
                check_eq($sformatf("R4 done latency vec %0d", i), lat, EXP_WE + 2);
                check_eq($sformatf("R4 ready with done vec %0d", i), turn, 0);
            end else begin
                check_eq($sformatf("R3 read data vec %0d", i), rd, VECS[i].d);
                check_eq($sformatf("R3 read window vec %0d", i), rd_lo, EXP_RD);
                check_eq($sformatf("R3 done latency vec %0d", i), lat, EXP_RD + 1);
                check_eq($sformatf("R7 turnaround vec %0d", i), turn, EXP_TURN);
            end
        end

        // R2: request while busy is ignored
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00001;
        @(negedge clk);
        req_write = 1'b1; req_wdata = 8'h00;
        for (int k = 0; k < 5; k++) begin
            check_eq("R2 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        done_exp++;
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        check_eq("R2 no cycle after busy request", mem_sel_n, 1);
        run_txn(1'b0, 18'h00001, 8'h00, rd, lat, wr_lo, rd_lo, turn, bad);
        check_eq("R2 busy write ignored", rd, 8'hFF);

        // R1: reset in the middle of a read
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h2AAAA;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R3 rd_n low mid read", mem_rd_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_eq("R1 reset aborts read: deselect", {mem_sel_n, mem_sel, mem_rd_n, mem_wr_n}, 4'b1011);
        check_eq("R1 reset aborts read: ready", req_ready, 1);
        check_eq("R1 reset aborts read: no drive", mem_dq_oe, 0);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(1'b0, 18'h3FFFF, 8'h00, rd, lat, wr_lo, rd_lo, turn, bad);
        check_eq("R3 read after reset", rd, 8'hC3);

        // Write right after a read: turnaround protects the bus
        run_txn(1'b0, 18'h00000, 8'h00, rd, lat, wr_lo, rd_lo, turn, bad);
        run_txn(1'b1, 18'h20000, 8'h81, rd, lat, wr_lo, rd_lo, turn, bad);
        run_txn(1'b0, 18'h20000, 8'h00, rd, lat, wr_lo, rd_lo, turn, bad);
        check_eq("R4 write after read stored", rd, 8'h81);

        repeat (20) @(negedge clk);
        check_eq("R6 model timing/contention violations", m_viol, 0);
        check_eq("R8 done pulse count", done_seen, done_exp);
        finish_run();
    end
endmodule